// File: doc/BRIEF.md
# Two-Road Traffic Light Sequencer

This block runs the signal heads of a crossing where two roads, A and B, meet. Each road has four lamps: red, amber, green and a left-turn arrow. The block steps through a fixed, repeating cycle. Road A gets green, then its left-turn arrow, then amber, while road B stays red. Road B then takes the same three phases while road A stays red. The cycle then starts again at road A green. Every lamp output is active high.

Time moves forward only on a one-cycle-wide, once-per-second tick enable that the surrounding logic supplies. The block keeps two down-counters. One holds the time left in the current go, turn or amber phase. The other holds the time left in the half-cycle that the opposing road spends on red. Each road shows its own remaining time on two common-cathode seven-segment digits. A road that has right of way shows the phase time. A road on red shows the red half-cycle time. The segment patterns are decoded inside the block.

Phase lengths are parameters that default to 45, 10 and 5 seconds. The red half-cycle is their sum, 60 seconds by default. A digit decoder that receives a code from 10 to 15 turns all of its segments off.

Top module: `traffic_pair_ctrl`

## Requirements
- R1: In the first cycle after a synchronous reset, road A shows green and road B shows red. Road A's digits show the green length (45) and road B's digits show the red length (60).
- R2: At every cycle after reset, exactly one of the four lamps of each road is on.
- R3: The phases run in this order: A green, A left-turn, A amber, B green, B left-turn, B amber, then A green again. While one road shows green, left-turn or amber, the other road shows red.
- R4: Measured in ticks, green lasts GO_S, left-turn lasts TURN_S and amber lasts AMBER_S.
- R5: On each tick the active phase count drops by one. In a cycle with no tick, every count and every lamp holds its value.
- R6: The phase changes on the tick that finds the active count at 1. The full length of the next phase is shown on that same tick, so a displayed value is never 0.
- R7: The red road's digits count down from GO_S+TURN_S+AMBER_S. They reach 1 together with the last second of the opposing amber phase, and they reload on the tick on which right of way passes to the other road.
- R8: Segment bits are ordered {g,f,e,d,c,b,a}, with bit 0 for segment a, and a lit segment is 1. Digits 0 to 9 are encoded as 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex). The tens digit shows 0 for values below 10.
- R9: Reset takes priority over the tick. A cycle with both reset and tick high gives the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_1s | input | 1 | One-cycle enable, once per second |
| a_red | output | 1 | Road A red lamp |
| a_amber | output | 1 | Road A amber lamp |
| a_go | output | 1 | Road A green lamp |
| a_turn | output | 1 | Road A left-turn lamp |
| b_red | output | 1 | Road B red lamp |
| b_amber | output | 1 | Road B amber lamp |
| b_go | output | 1 | Road B green lamp |
| b_turn | output | 1 | Road B left-turn lamp |
| a_seg_tens | output | 7 | Road A tens digit, {g..a} |
| a_seg_ones | output | 7 | Road A ones digit, {g..a} |
| b_seg_tens | output | 7 | Road B tens digit, {g..a} |
| b_seg_ones | output | 7 | Road B ones digit, {g..a} |

## Verification
A bench model that is written from the requirements is compared against all lamps and all digit patterns in every cycle. The tick is driven at random from a fixed seed, with gaps of several idle cycles. These gaps separate counting on ticks from counting on clock cycles. A long dense-tick stretch runs several full cycles, which exercises every phase boundary and both reloads of the red half-cycle. Durations are also measured from lamp changes alone, so a length error is reported even if the model were wrong in the same way. Directed resets check the start-up values and the digit encodings, and one of them arrives together with a tick to check reset priority.

// File: rtl/tl_pkg.sv
package tl_pkg;

    localparam int CNT_W = 7;   // holds values up to 99
    localparam int SEG_W = 7;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [SEG_W-1:0] seg_t;

    typedef enum logic [2:0] {
        PH_A_GO    = 3'd0,
        PH_A_TURN  = 3'd1,
        PH_A_AMBER = 3'd2,
        PH_B_GO    = 3'd3,
        PH_B_TURN  = 3'd4,
        PH_B_AMBER = 3'd5
    } phase_e;

    typedef struct packed {
        logic red;
        logic amber;
        logic go;
        logic turn;
    } lamps_t;

    typedef struct packed {
        logic [3:0] tens;
        logic [3:0] ones;
    } bcd2_t;

    function automatic phase_e next_phase(phase_e p);
        case (p)
            PH_A_GO:    return PH_A_TURN;
            PH_A_TURN:  return PH_A_AMBER;
            PH_A_AMBER: return PH_B_GO;
            PH_B_GO:    return PH_B_TURN;
            PH_B_TURN:  return PH_B_AMBER;
            default:    return PH_A_GO;
        endcase
    endfunction

    function automatic logic a_has_way(phase_e p);
        return (p == PH_A_GO) || (p == PH_A_TURN) || (p == PH_A_AMBER);
    endfunction

    function automatic logic is_amber(phase_e p);
        return (p == PH_A_AMBER) || (p == PH_B_AMBER);
    endfunction

    function automatic lamps_t way_lamps(phase_e p);
        lamps_t l;
        l = '0;
        case (p)
            PH_A_GO, PH_B_GO:       l.go    = 1'b1;
            PH_A_TURN, PH_B_TURN:   l.turn  = 1'b1;
            default:                l.amber = 1'b1;
        endcase
        return l;
    endfunction

    function automatic bcd2_t to_bcd2(cnt_t v);
        bcd2_t r;
        r.tens = 4'(v / cnt_t'(10));
        r.ones = 4'(v % cnt_t'(10));
        return r;
    endfunction

endpackage

// File: rtl/tl_countdown.sv
module tl_countdown
    import tl_pkg::*;
#(
    parameter int START = 45
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  cnt_t reload,
    output cnt_t count,
    output logic at_end
);

    always_ff @(posedge clk) begin
        if (rst)
            count <= cnt_t'(START);
        else if (tick) begin
            if (count == cnt_t'(1))
                count <= reload;
            else
                count <= count - cnt_t'(1);
        end
    end

    assign at_end = (count == cnt_t'(1));

    // R6
    count_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        count != '0);

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && count > cnt_t'(1)) |=> (count == $past(count) - cnt_t'(1)));

    // R5
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count));

endmodule

// File: rtl/tl_phase_seq.sv
module tl_phase_seq
    import tl_pkg::*;
#(
    parameter int GO_S    = 45,
    parameter int TURN_S  = 10,
    parameter int AMBER_S = 5
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   act_end,
    output phase_e phase,
    output cnt_t   next_len
);

    phase_e upcoming;

    always_ff @(posedge clk) begin
        if (rst)
            phase <= PH_A_GO;
        else if (tick && act_end)
            phase <= upcoming;
    end

    always_comb begin
        upcoming = next_phase(phase);
        case (upcoming)
            PH_A_GO, PH_B_GO:     next_len = cnt_t'(GO_S);
            PH_A_TURN, PH_B_TURN: next_len = cnt_t'(TURN_S);
            default:              next_len = cnt_t'(AMBER_S);
        endcase
    end

    // R6
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(tick && act_end) |=> $stable(phase));

    // R3
    phase_order_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && act_end) |=> (phase == next_phase($past(phase))));

endmodule

// File: rtl/tl_seg_decode.sv
module tl_seg_decode
    import tl_pkg::*;
(
    input  logic [3:0] digit,
    output seg_t       seg
);

    always_comb begin
        case (digit)
            4'd0:    seg = 7'h3F;
            4'd1:    seg = 7'h06;
            4'd2:    seg = 7'h5B;
            4'd3:    seg = 7'h4F;
            4'd4:    seg = 7'h66;
            4'd5:    seg = 7'h6D;
            4'd6:    seg = 7'h7D;
            4'd7:    seg = 7'h07;
            4'd8:    seg = 7'h7F;
            4'd9:    seg = 7'h6F;
            default: seg = '0;   // codes 10..15 stay dark
        endcase
    end

endmodule

// File: rtl/traffic_pair_ctrl.sv
module traffic_pair_ctrl
    import tl_pkg::*;
#(
    parameter int GO_S    = 45,
    parameter int TURN_S  = 10,
    parameter int AMBER_S = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_1s,
    output logic       a_red,
    output logic       a_amber,
    output logic       a_go,
    output logic       a_turn,
    output logic       b_red,
    output logic       b_amber,
    output logic       b_go,
    output logic       b_turn,
    output logic [6:0] a_seg_tens,
    output logic [6:0] a_seg_ones,
    output logic [6:0] b_seg_tens,
    output logic [6:0] b_seg_ones
);

    localparam int RED_S = GO_S + TURN_S + AMBER_S;
    localparam int N_DIG = 4;

    initial begin
        red_fits_chk: assert (RED_S <= 99 && AMBER_S >= 1 && TURN_S >= 1 && GO_S >= 1);
    end

    phase_e phase;
    cnt_t   next_len;
    cnt_t   act_cnt, red_cnt;
    logic   act_end, red_end;
    lamps_t lamp_a, lamp_b, lamp_red;
    bcd2_t  bcd_a, bcd_b;
    logic [3:0] dig [N_DIG];
    seg_t       seg [N_DIG];

    tl_phase_seq #(.GO_S(GO_S), .TURN_S(TURN_S), .AMBER_S(AMBER_S)) u_seq (
        .clk(clk), .rst(rst), .tick(tick_1s), .act_end(act_end),
        .phase(phase), .next_len(next_len)
    );

    tl_countdown #(.START(GO_S)) u_act_cnt (
        .clk(clk), .rst(rst), .tick(tick_1s), .reload(next_len),
        .count(act_cnt), .at_end(act_end)
    );

    tl_countdown #(.START(RED_S)) u_red_cnt (
        .clk(clk), .rst(rst), .tick(tick_1s), .reload(cnt_t'(RED_S)),
        .count(red_cnt), .at_end(red_end)
    );

    always_comb begin
        lamp_red     = '0;
        lamp_red.red = 1'b1;
        if (a_has_way(phase)) begin
            lamp_a = way_lamps(phase);
            lamp_b = lamp_red;
            bcd_a  = to_bcd2(act_cnt);
            bcd_b  = to_bcd2(red_cnt);
        end else begin
            lamp_a = lamp_red;
            lamp_b = way_lamps(phase);
            bcd_a  = to_bcd2(red_cnt);
            bcd_b  = to_bcd2(act_cnt);
        end
    end

    assign dig[0] = bcd_a.tens;
    assign dig[1] = bcd_a.ones;
    assign dig[2] = bcd_b.tens;
    assign dig[3] = bcd_b.ones;

    for (genvar d = 0; d < N_DIG; d++) begin : g_dig
        tl_seg_decode u_dec (.digit(dig[d]), .seg(seg[d]));
    end

    assign {a_red, a_amber, a_go, a_turn} = lamp_a;
    assign {b_red, b_amber, b_go, b_turn} = lamp_b;
    assign a_seg_tens = seg[0];
    assign a_seg_ones = seg[1];
    assign b_seg_tens = seg[2];
    assign b_seg_ones = seg[3];

    // R2
    one_lamp_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({a_red, a_amber, a_go, a_turn}) == 1 &&
        $countones({b_red, b_amber, b_go, b_turn}) == 1);

    // R3
    conflict_free_chk: assert property (@(posedge clk) disable iff (rst)
        (a_go || a_turn || a_amber) |-> b_red);

    // R7
    red_align_chk: assert property (@(posedge clk) disable iff (rst)
        red_end == (act_end && is_amber(phase)));

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (phase == PH_A_GO && act_cnt == cnt_t'(GO_S) &&
                        red_cnt == cnt_t'(RED_S)));

endmodule

// File: tb/tb_traffic_pair_ctrl.sv
`timescale 1ns/1ps
module tb_traffic_pair_ctrl;

    localparam int GO_S = 45, TURN_S = 10, AMBER_S = 5;
    localparam int RED_S = GO_S + TURN_S + AMBER_S;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_1s = 1'b0;
    logic a_red, a_amber, a_go, a_turn, b_red, b_amber, b_go, b_turn;
    logic [6:0] a_seg_tens, a_seg_ones, b_seg_tens, b_seg_ones;

    int checks = 0;
    int errors = 0;

    // model state
    int m_ph, m_cnt, m_red;
    // observed-duration tracking
    int obs_prev, obs_ticks;
    logic obs_valid;

    always #2.5 clk = ~clk;

    traffic_pair_ctrl #(.GO_S(GO_S), .TURN_S(TURN_S), .AMBER_S(AMBER_S)) dut (
        .clk(clk), .rst(rst), .tick_1s(tick_1s),
        .a_red(a_red), .a_amber(a_amber), .a_go(a_go), .a_turn(a_turn),
        .b_red(b_red), .b_amber(b_amber), .b_go(b_go), .b_turn(b_turn),
        .a_seg_tens(a_seg_tens), .a_seg_ones(a_seg_ones),
        .b_seg_tens(b_seg_tens), .b_seg_ones(b_seg_ones)
    );

    function automatic logic [6:0] exp_seg(int d);
        case (d)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; 9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    function automatic int ph_len(int p);
        case (p % 3)
            0: return GO_S;
            1: return TURN_S;
            default: return AMBER_S;
        endcase
    endfunction

    // lamps {red, amber, go, turn} expected for road r (0 = A, 1 = B)
    function automatic logic [3:0] exp_lamps(int p, int r);
        if ((p < 3) != (r == 0)) return 4'b1000;
        case (p % 3)
            0: return 4'b0010;
            1: return 4'b0001;
            default: return 4'b0100;
        endcase
    endfunction

    // phase index recovered from lamps only, -1 if illegal
    function automatic int obs_phase();
        if (b_red && a_go)    return 0;
        if (b_red && a_turn)  return 1;
        if (b_red && a_amber) return 2;
        if (a_red && b_go)    return 3;
        if (a_red && b_turn)  return 4;
        if (a_red && b_amber) return 5;
        return -1;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ph = 0; m_cnt = GO_S; m_red = RED_S;
        obs_valid = 1'b0;
    endtask

    task automatic model_tick();
        if (m_cnt == 1) begin
            m_ph = (m_ph + 1) % 6;
            m_cnt = ph_len(m_ph);
        end else m_cnt--;
        if (m_red == 1) m_red = RED_S; else m_red--;
    endtask

    task automatic compare_all(logic was_tick);
        int da, db, op;
        da = (m_ph < 3) ? m_cnt : m_red;
        db = (m_ph < 3) ? m_red : m_cnt;
        // R2
        chk("R2", "one lamp road A", $countones({a_red, a_amber, a_go, a_turn}), 1);
        chk("R2", "one lamp road B", $countones({b_red, b_amber, b_go, b_turn}), 1);
        // R3
        chk("R3", "lamps road A", {a_red, a_amber, a_go, a_turn}, exp_lamps(m_ph, 0));
        chk("R3", "lamps road B", {b_red, b_amber, b_go, b_turn}, exp_lamps(m_ph, 1));
        // R5 / R7: active road uses phase count, red road uses half-cycle count
        if (m_ph < 3) begin
            chk("R5", "A ones", a_seg_ones, exp_seg(da % 10));
            chk("R5", "A tens", a_seg_tens, exp_seg(da / 10));
            chk("R7", "B red ones", b_seg_ones, exp_seg(db % 10));
            chk("R7", "B red tens", b_seg_tens, exp_seg(db / 10));
        end else begin
            chk("R7", "A red ones", a_seg_ones, exp_seg(da % 10));
            chk("R7", "A red tens", a_seg_tens, exp_seg(da / 10));
            chk("R5", "B ones", b_seg_ones, exp_seg(db % 10));
            chk("R5", "B tens", b_seg_tens, exp_seg(db / 10));
        end
        // R6: never a displayed zero on both digits
        chk("R6", "A not 00", int'({a_seg_tens, a_seg_ones} == {7'h3F, 7'h3F}), 0);
        chk("R6", "B not 00", int'({b_seg_tens, b_seg_ones} == {7'h3F, 7'h3F}), 0);
        // R4: durations measured from lamp changes only
        op = obs_phase();
        if (was_tick) obs_ticks++;
        if (op != obs_prev) begin
            if (obs_valid && obs_prev >= 0)
                chk("R4", "phase length", obs_ticks, ph_len(obs_prev));
            obs_valid = 1'b1;
            obs_ticks = 0;
        end
        obs_prev = op;
    endtask

    task automatic check_reset_state(string req);
        chk(req, "A lamps", {a_red, a_amber, a_go, a_turn}, 4'b0010);
        chk(req, "B lamps", {b_red, b_amber, b_go, b_turn}, 4'b1000);
        // R8: 45 -> 66,6D ; 60 -> 7D,3F
        chk("R8", "A tens 4", a_seg_tens, 7'h66);
        chk("R8", "A ones 5", a_seg_ones, 7'h6D);
        chk("R8", "B tens 6", b_seg_tens, 7'h7D);
        chk("R8", "B ones 0", b_seg_ones, 7'h3F);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic t_prev, r_prev;
        void'($urandom(32'd1234));
        model_reset();
        obs_prev = 0; obs_ticks = 0;
        rst = 1'b1; tick_1s = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: start-up state
        check_reset_state("R1");
        obs_prev = obs_phase();

        // idle cycles: nothing may move (R5)
        repeat (5) begin
            @(negedge clk);
            compare_all(1'b0);
        end

        t_prev = 1'b0; r_prev = 1'b0;
        for (int cyc = 0; cyc < 9000; cyc++) begin
            // drive for the coming edge
            if (cyc == 4000) begin
                // R9: reset together with tick
                rst = 1'b1; tick_1s = 1'b1;
            end else begin
                rst = 1'b0;
                if (cyc < 2000)      tick_1s = ($urandom_range(0, 3) == 0);
                else                 tick_1s = ($urandom_range(0, 9) != 0);
            end
            t_prev = tick_1s; r_prev = rst;
            @(negedge clk);
            if (r_prev) begin
                model_reset();
                check_reset_state("R9");
                obs_prev = obs_phase();
            end else begin
                if (t_prev) model_tick();
                compare_all(t_prev);
            end
        end

        // R6/R8: run to amber's last second on road A, then step once
        rst = 1'b1; tick_1s = 1'b0;
        @(negedge clk);
        rst = 1'b0; model_reset();
        @(negedge clk);
        obs_prev = obs_phase();
        tick_1s = 1'b1;
        repeat (GO_S + TURN_S + AMBER_S - 1) begin
            @(negedge clk);
            model_tick();
            compare_all(1'b1);
        end
        tick_1s = 1'b0;
        @(negedge clk);
        chk("R8", "A ones 1 on amber", a_seg_ones, 7'h06);
        chk("R7", "B red at 1", b_seg_ones, 7'h06);
        tick_1s = 1'b1;
        @(negedge clk);
        tick_1s = 1'b0;
        model_tick();
        compare_all(1'b1);
        // R6: B go shows 45 on the switching tick, A red reloads to 60
        chk("R6", "B go lamp", b_go, 1);
        chk("R6", "B tens after switch", b_seg_tens, 7'h66);
        chk("R7", "A red reloaded", a_seg_tens, 7'h7D);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule